// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that gives an external bus master read and write access to a bank of 128 byte-wide registers held inside it. SCL and SDA arrive already synchronised to the system clock. The block drives SDA only as an open-drain enable: when `sda_oe_o` is high, the line is pulled low. The bus is oversampled by the system clock. START, repeated START and STOP are detected as SDA edges while SCL is high. Shifting happens on SCL edges.

A transaction starts with an address byte. The upper six address bits are a parameter and the lowest address bit comes from a strap pin. After an acknowledged write address, the next byte is an index byte. Its low seven bits select a register and its top bit turns on pointer auto-increment. Further bytes in the same direction are stored into the bank. To read, the master writes the index, issues a repeated START with the read direction, and then clocks bytes out. It acknowledges each byte until it wants to stop.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0) and every register reads back as 0x00.
- R2: An address byte is acknowledged only when its bits 7:1 equal 0011 10s binary, where s is `addr_sel_i`. This gives 0x38/0x39 (write/read) with the strap low and 0x3A/0x3B with the strap high; bit 0 = 1 selects a read.
- R3: On an address mismatch SDA stays released, and later bytes are neither acknowledged nor stored until the next START or STOP.
- R4: Every byte the target receives (address, index, write data) is acknowledged by holding SDA low through the whole high phase of the ninth clock.
- R5: In the index byte, bits 6:0 select the register and bit 7 = 0 disables auto-increment, so successive data bytes all write, or all read, the same register.
- R6: With index bit 7 = 1, each written data byte goes to the current register and the pointer then advances by one.
- R7: A read returns the addressed register, MSB first; while the master acknowledges, the target sends further bytes, advancing the pointer when auto-increment is on.
- R8: A not-acknowledge from the master ends transmission; SDA stays released for any further clocks until a START or STOP.
- R9: The auto-incrementing pointer wraps from 127 to 0.
- R10: A STOP at any point returns the target to idle without writing a partial byte; a repeated START restarts address matching but keeps the register pointer.
- R11: The target changes `sda_oe_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| addr_sel_i | input | 1 | Strap that supplies address bit 0 |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
A wrong register pointer shows up in the first data byte read after the index is set. A missed or extra increment shifts every later byte of a burst by one register, which is why full 128-byte bursts are compared against an arithmetic pattern. A state machine that falls out of step with the bit count shows within one byte time: an acknowledge lands in the wrong bit slot, or the target pulls SDA during a slot that belongs to the master. An address decode error shows on the ninth clock of the address byte, and the sweep covers all 256 address bytes under both strap values.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_IGNORE
   } tgt_state_e;

endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  =  scl_i & ~scl_q;
   assign scl_fall  = ~scl_i &  scl_q;
   assign start_det =  scl_i &  scl_q &  sda_q & ~sda_i;
   assign stop_det  =  scl_i &  scl_q & ~sda_q &  sda_i;

   a_r10_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({scl_rise, scl_fall, start_det, stop_det}) <= 1);

endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
   parameter int unsigned IDX_W          = 7,
   parameter int unsigned DATA_W         = 8,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_idx] <= wr_data;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_idx] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = mem[rd_idx];

   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_tgt_pkg::*;
#(
   parameter logic [5:0]  ADDR_UPPER = 6'b001110,
   parameter int unsigned IDX_W      = 7,
   parameter int unsigned DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              addr_sel_i,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [DATA_W-1:0] rd_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              sda_oe
);

   localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
   localparam int unsigned BIT_IW = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

   tgt_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] tx;
   logic [IDX_W-1:0]  ptr;
   logic              inc_q;
   logic              rd_dir;
   logic              mst_ack;
   logic [6:0]        own_addr;
   logic              in_byte;

   assign own_addr = {ADDR_UPPER, addr_sel_i};
   assign in_byte  = (state == ST_ADDR) || (state == ST_SUB) ||
                     (state == ST_WR)   || (state == ST_RD);
   assign rd_idx   = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         tx      <= '0;
         ptr     <= '0;
         inc_q   <= 1'b0;
         rd_dir  <= 1'b0;
         mst_ack <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            state  <= ST_ADDR;
            sda_oe <= 1'b0;
            cnt    <= '0;
         end else begin
            if (scl_rise) begin
               if (in_byte) begin
                  shreg <= {shreg[DATA_W-2:0], sda_i};
                  cnt   <= cnt + 1'b1;
               end
               if (state == ST_RD_ACK) mst_ack <= ~sda_i;
            end
            if (scl_fall) begin
               case (state)
                  ST_ADDR: begin
                     if (cnt == FULL_CNT) begin
                        if (shreg[7:1] == own_addr) begin
                           state  <= ST_ADDR_ACK;
                           sda_oe <= 1'b1;
                           rd_dir <= shreg[0];
                        end else begin
                           state  <= ST_IGNORE;
                        end
                     end
                  end
                  ST_ADDR_ACK: begin
                     cnt <= '0;
                     if (rd_dir) begin
                        state  <= ST_RD;
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                     end else begin
                        state  <= ST_SUB;
                        sda_oe <= 1'b0;
                     end
                  end
                  ST_SUB: begin
                     if (cnt == FULL_CNT) begin
                        ptr    <= shreg[IDX_W-1:0];
                        inc_q  <= shreg[7];
                        state  <= ST_SUB_ACK;
                        sda_oe <= 1'b1;
                     end
                  end
                  ST_SUB_ACK, ST_WR_ACK: begin
                     state  <= ST_WR;
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                  end
                  ST_WR: begin
                     if (cnt == FULL_CNT) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= ptr;
                        wr_data <= shreg;
                        if (inc_q) ptr <= ptr + 1'b1;
                        state   <= ST_WR_ACK;
                        sda_oe  <= 1'b1;
                     end
                  end
                  ST_RD: begin
                     if (cnt == FULL_CNT) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RD_ACK;
                        if (inc_q) ptr <= ptr + 1'b1;
                     end else begin
                        sda_oe <= ~tx[BIT_IW'(DATA_W - 1) - BIT_IW'(cnt)];
                     end
                  end
                  ST_RD_ACK: begin
                     if (mst_ack) begin
                        state  <= ST_RD;
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                        cnt    <= '0;
                     end else begin
                        state  <= ST_IGNORE;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   a_r11_sda_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i)) |-> $stable(sda_oe));

   a_r3_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> (!sda_oe && !wr_en));

   a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_oe));

   a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_fall && state == ST_WR && cnt == FULL_CNT && inc_q)
      |=> (ptr == $past(ptr) + IDX_W'(1)));

   a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_fall && state == ST_WR && cnt == FULL_CNT && !inc_q)
      |=> (ptr == $past(ptr)));

   a_r4_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUB_ACK && scl_i) |-> sda_oe);

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
   parameter logic [5:0]  ADDR_UPPER     = 6'b001110,
   parameter int unsigned IDX_W          = 7,
   parameter int unsigned DATA_W         = 8,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic addr_sel_i,
   output logic sda_oe_o
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("i2c_regbank_target: bus bytes are 8 bits wide");
      end
      if (IDX_W < 1 || IDX_W > 7) begin : g_bad_index
         $error("i2c_regbank_target: index width must be 1..7");
      end
   endgenerate

   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic [DATA_W-1:0] rd_data;
   logic [IDX_W-1:0]  rd_idx;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_data;

   i2c_bus_events u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_tgt_fsm #(
      .ADDR_UPPER (ADDR_UPPER),
      .IDX_W      (IDX_W),
      .DATA_W     (DATA_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .addr_sel_i (addr_sel_i),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .rd_data    (rd_data),
      .rd_idx     (rd_idx),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .sda_oe     (sda_oe_o)
   );

   i2c_reg_array #(
      .IDX_W          (IDX_W),
      .DATA_W         (DATA_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

endmodule

// File: tb/tb_i2c_regbank_target.sv
module tb_i2c_regbank_target;

   localparam int Q = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_oe = 1'b0;
   logic strap = 1'b0;
   logic dut_oe;
   logic sda_line;

   int checks = 0;
   int fails = 0;
   int viol = 0;
   logic scl_prev = 1'b1;
   logic oe_prev = 1'b0;

   assign sda_line = ~(dut_oe | m_oe);

   always #10 clk = ~clk;

   i2c_regbank_target dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_line),
      .addr_sel_i (strap),
      .sda_oe_o   (dut_oe)
   );

   always @(negedge clk) begin
      if (rst_n && scl && scl_prev && (dut_oe != oe_prev)) viol++;
      scl_prev <= scl;
      oe_prev  <= dut_oe;
   end

   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 11) & 8'hFF);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(logic b);
      m_oe = ~b; wt(Q);
      scl = 1'b1; wt(2 * Q);
      scl = 1'b0; wt(Q);
   endtask

   task automatic bit_in(output logic b);
      m_oe = 1'b0; wt(Q);
      scl = 1'b1; wt(Q);
      b = sda_line; wt(Q);
      scl = 1'b0; wt(Q);
   endtask

   task automatic send_byte(logic [7:0] b, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(a);
      ack = ~a;
   endtask

   task automatic recv_byte(logic give_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         d[i] = b;
      end
      bit_out(~give_ack);
   endtask

   task automatic bus_start();
      m_oe = 1'b0; wt(Q);
      scl = 1'b1; wt(Q);
      m_oe = 1'b1; wt(Q);
      scl = 1'b0; wt(Q);
   endtask

   task automatic bus_stop();
      m_oe = 1'b1; wt(Q);
      scl = 1'b1; wt(Q);
      m_oe = 1'b0; wt(Q);
   endtask

   task automatic begin_write(logic [7:0] sub);
      logic ack;
      bus_start();
      send_byte(8'h38, ack); chk(ack, "R4 addr ack", ack, 1);
      send_byte(sub, ack);   chk(ack, "R4 index ack", ack, 1);
   endtask

   task automatic begin_read(logic [7:0] sub);
      logic ack;
      begin_write(sub);
      bus_start();
      send_byte(8'h39, ack); chk(ack, "R7 read addr ack", ack, 1);
   endtask

   initial begin
      logic ack;
      logic [7:0] d;
      wt(5);
      rst_n = 1'b1;
      wt(2);

      chk(dut_oe == 1'b0, "R1 sda released", dut_oe, 0);
      begin_read(8'h80);
      for (int i = 0; i < 4; i++) begin
         recv_byte(i != 3, d);
         chk(d == 8'h00, "R1 reg cleared", d, 0);
      end
      bus_stop();

      // R2: every address byte under both strap values
      for (int s = 0; s < 2; s++) begin
         strap = s[0];
         wt(2);
         for (int b = 0; b < 256; b++) begin
            logic expa;
            bus_start();
            send_byte(8'(b), ack);
            expa = (b[7:1] == {6'b001110, s[0]});
            chk(ack == expa, "R2 address decode", ack, expa);
            if (ack && b[0]) recv_byte(1'b0, d);
            bus_stop();
         end
      end
      strap = 1'b0;
      wt(2);

      // R6: full auto-increment write burst
      begin_write(8'h80);
      for (int i = 0; i < 128; i++) begin
         send_byte(pat(i), ack);
         chk(ack, "R6 data ack", ack, 1);
      end
      bus_stop();

      // R7: full burst read back
      begin_read(8'h80);
      for (int i = 0; i < 128; i++) begin
         recv_byte(i != 127, d);
         chk(d == pat(i), "R7 burst read", d, pat(i));
      end
      // R8: after NACK the line stays released
      recv_byte(1'b0, d);
      chk(d == 8'hFF, "R8 released after nack", d, 8'hFF);
      bus_stop();

      // R3: mismatched address, later bytes ignored
      bus_start();
      send_byte(8'h3A, ack); chk(!ack, "R3 addr nack", ack, 0);
      send_byte(8'h05, ack); chk(!ack, "R3 index ignored", ack, 0);
      send_byte(8'h99, ack); chk(!ack, "R3 data ignored", ack, 0);
      bus_stop();
      begin_read(8'h05);
      recv_byte(1'b0, d);
      chk(d == pat(5), "R3 reg untouched", d, pat(5));
      bus_stop();

      // R5: no auto-increment
      begin_write(8'h10);
      send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
      chk(ack, "R5 data ack", ack, 1);
      bus_stop();
      begin_read(8'h10);
      recv_byte(1'b1, d); chk(d == 8'h33, "R5 same reg first", d, 8'h33);
      recv_byte(1'b0, d); chk(d == 8'h33, "R5 same reg second", d, 8'h33);
      bus_stop();
      begin_read(8'h11);
      recv_byte(1'b0, d); chk(d == pat(17), "R5 neighbour untouched", d, pat(17));
      bus_stop();

      // R9: wrap 127 -> 0
      begin_write(8'hFF);
      send_byte(8'hC1, ack); send_byte(8'hC2, ack);
      bus_stop();
      begin_read(8'hFF);
      recv_byte(1'b1, d); chk(d == 8'hC1, "R9 reg 127", d, 8'hC1);
      recv_byte(1'b0, d); chk(d == 8'hC2, "R9 wrapped to reg 0", d, 8'hC2);
      bus_stop();

      // R10: STOP inside a data byte, then repeated START keeps pointer
      begin_write(8'h85);
      send_byte(8'h5A, ack);
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
      bus_stop();
      begin_read(8'h85);
      recv_byte(1'b1, d); chk(d == 8'h5A, "R10 full byte kept", d, 8'h5A);
      recv_byte(1'b0, d); chk(d == pat(6), "R10 partial byte dropped", d, pat(6));
      bus_stop();
      begin_write(8'h88);
      send_byte(8'h77, ack);
      bus_start();
      send_byte(8'h39, ack); chk(ack, "R10 restart ack", ack, 1);
      recv_byte(1'b0, d); chk(d == pat(9), "R10 pointer kept", d, pat(9));
      bus_stop();

      chk(viol == 0, "R11 sda change with scl high", viol, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule